// File: doc/BRIEF.md
# Priority-Watermarked Retry-Aware Descriptor Scheduler

This block holds the packet descriptors queued for one switch port and decides which one goes to the link next. Each descriptor carries a packet ID and a 2-bit priority, where 3 is the highest. Up to eight descriptors are held in a shared buffer. The ingress side offers descriptors with a valid/ready handshake. Admission depends on the current total occupancy and on a per-priority watermark. When a descriptor is refused, ready stays low and the producer keeps the descriptor until space frees. Payload, framing and data movement are handled elsewhere; only descriptors are stored and ordered.

The egress side presents one descriptor at a time to the link. The link answers the presented descriptor with accept or retry. An accepted descriptor leaves the buffer. A retried descriptor stays in the buffer and keeps its place in arrival order. Normally the oldest descriptor is presented, whatever its priority. After a retry, the next presentation is the oldest descriptor of the highest priority now buffered. After that single presentation, the scheduler goes back to oldest-first.

A mode input selects between two watermark sets. Fair-share mode places no limit beyond the buffer depth. High-priority mode keeps space free for the upper priorities.

Top module: `prio_wm_sched`

## Requirements
- R1: After reset the buffer is empty, `tx_valid` is 0, and `in_ready` is 1 for every priority.
- R2: When no retry is pending, the descriptor presented on `tx_id`/`tx_prio` is the earliest-arrived one still buffered, whatever the priorities.
- R3: A response with `resp_valid`=1 and `resp_retry`=1, given to an oldest-first presentation, makes the next presentation the earliest-arrived descriptor among those with the highest buffered priority.
- R4: A priority-selected presentation happens exactly once. After any response to it (accept or retry), the scheduler presents the earliest-arrived descriptor again, which may be the one that was retried.
- R5: A retry response (`resp_retry`=1) leaves the descriptor in the buffer with its arrival position unchanged. Only an accept (`resp_valid`=1, `resp_retry`=0) removes it.
- R6: With `hi_prio_mode`=1, a descriptor is admitted only while the occupancy is below its watermark: priority 3 below 8, priority 2 below 6, priority 1 below 4, priority 0 below 2.
- R7: With `hi_prio_mode`=0, a descriptor of any priority is admitted while the occupancy is below 8.
- R8: A descriptor over its watermark is neither stored nor dropped. `in_ready` stays 0 until the occupancy falls, and the occupancy never exceeds 8.
- R9: When all buffered descriptors share one priority, the presentation that follows a retry is the same descriptor that oldest-first would choose.
- R10: An admission and an accept in the same cycle leave the occupancy unchanged. Occupancy is updated in the cycle of the handshake.
- R11: `tx_valid` is 1 exactly when the buffer is non-empty. A response while `tx_valid`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_prio_mode | input | 1 | 1 = high-priority watermarks, 0 = fair-share (no limit below depth) |
| in_valid | input | 1 | Ingress descriptor offered |
| in_id | input | ID_W | Ingress packet ID |
| in_prio | input | 2 | Ingress priority, 3 highest |
| in_ready | output | 1 | Descriptor admitted this cycle if in_valid |
| tx_valid | output | 1 | A descriptor is presented to the link |
| tx_id | output | ID_W | Presented packet ID |
| tx_prio | output | 2 | Presented packet priority |
| resp_valid | input | 1 | Link response for the presented descriptor |
| resp_retry | input | 1 | 1 = retry, 0 = accept |

## Verification
The hardest situation to reach is a retry that lands while the buffer holds mixed priorities. In that state the oldest descriptor and the oldest of the top priority are different entries, and a higher-priority descriptor arrived after a lower one. The bench first loads a low-priority descriptor and then several higher ones. It retries the oldest, retries the priority pick again, and then accepts. This shows that the retried descriptor comes back as the oldest and is not lost. A second case holds a refused descriptor on the ingress side while the link accepts. It checks that admission happens in the cycle after the occupancy falls.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int PRIO_W   = 2;
    localparam int NUM_PRIO = 1 << PRIO_W;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic {
        PICK_OLDEST = 1'b0,
        PICK_TOPPRIO = 1'b1
    } pick_e;

    // Admission limit on occupancy for one priority; clamped to the depth.
    function automatic int wm_limit(input logic hi_mode, input prio_t p, input int depth);
        int lim;
        if (!hi_mode) begin
            lim = depth;
        end else begin
            case (p)
                2'd3:    lim = 8;
                2'd2:    lim = 6;
                2'd1:    lim = 4;
                default: lim = 2;
            endcase
        end
        if (lim > depth) lim = depth;
        return lim;
    endfunction

endpackage

// File: rtl/sched_admit.sv
module sched_admit
    import sched_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             hi_mode,
    input  prio_t            req_prio,
    input  logic [CNT_W-1:0] occ,
    input  logic [DEPTH-1:0] used,
    output logic             ready,
    output logic [IDX_W-1:0] slot
);

    int lim;

    always_comb begin
        lim   = wm_limit(hi_mode, req_prio, DEPTH);
        ready = (int'(occ) < lim);
    end

    // Lowest unused entry; the watermark check ensures one exists when ready.
    always_comb begin
        slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) slot = IDX_W'(i);
        end
    end

endmodule

// File: rtl/sched_store.sv
module sched_store
    import sched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_slot,
    input  logic [ID_W-1:0]             wr_id,
    input  prio_t                       wr_prio,
    input  logic                        rm_en,
    input  logic [IDX_W-1:0]            rm_slot,
    output logic [DEPTH-1:0]            used,
    output logic [DEPTH-1:0][ID_W-1:0]  ids,
    output logic [DEPTH-1:0][PRIO_W-1:0] prios,
    output logic [DEPTH-1:0][IDX_W-1:0] ranks,
    output logic [CNT_W-1:0]            occ
);

    logic [IDX_W-1:0] rm_rank;
    logic [CNT_W-1:0] new_rank;

    assign rm_rank  = ranks[rm_slot];
    assign new_rank = occ - CNT_W'(rm_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= occ + CNT_W'(wr_en) - CNT_W'(rm_en);
        end
    end

    // Each entry keeps its arrival rank (0 = oldest). A removal moves every
    // later arrival one place forward.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                used[g]  <= 1'b0;
                ids[g]   <= '0;
                prios[g] <= '0;
                ranks[g] <= '0;
            end else if (wr_en && wr_slot == IDX_W'(g)) begin
                used[g]  <= 1'b1;
                ids[g]   <= wr_id;
                prios[g] <= wr_prio;
                ranks[g] <= IDX_W'(new_rank);
            end else if (rm_en && rm_slot == IDX_W'(g)) begin
                used[g]  <= 1'b0;
            end else if (rm_en && used[g] && ranks[g] > rm_rank) begin
                ranks[g] <= ranks[g] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sched_select.sv
module sched_select
    import sched_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             used,
    input  logic [DEPTH-1:0][PRIO_W-1:0] prios,
    input  logic [DEPTH-1:0][IDX_W-1:0]  ranks,
    input  pick_e                        pick,
    output logic                         any,
    output logic [IDX_W-1:0]             sel
);

    logic [IDX_W-1:0] old_idx;
    logic [IDX_W-1:0] top_idx;
    logic             top_found;
    prio_t            top_p;
    logic [IDX_W-1:0] top_r;

    // Entry with arrival rank zero.
    always_comb begin
        old_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (used[i] && ranks[i] == '0) old_idx = IDX_W'(i);
        end
    end

    // One pass: highest priority wins, earlier arrival breaks a tie.
    always_comb begin
        top_idx   = '0;
        top_found = 1'b0;
        top_p     = '0;
        top_r     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (used[i] && (!top_found || prios[i] > top_p ||
                            (prios[i] == top_p && ranks[i] < top_r))) begin
                top_found = 1'b1;
                top_idx   = IDX_W'(i);
                top_p     = prios[i];
                top_r     = ranks[i];
            end
        end
    end

    assign any = |used;
    assign sel = (pick == PICK_TOPPRIO) ? top_idx : old_idx;

endmodule

// File: rtl/prio_wm_sched.sv
module prio_wm_sched
    import sched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hi_prio_mode,
    input  logic            in_valid,
    input  logic [ID_W-1:0] in_id,
    input  logic [1:0]      in_prio,
    output logic            in_ready,
    output logic            tx_valid,
    output logic [ID_W-1:0] tx_id,
    output logic [1:0]      tx_prio,
    input  logic            resp_valid,
    input  logic            resp_retry
);

    logic [DEPTH-1:0]              used;
    logic [DEPTH-1:0][ID_W-1:0]    ids;
    logic [DEPTH-1:0][PRIO_W-1:0]  prios;
    logic [DEPTH-1:0][IDX_W-1:0]   ranks;
    logic [CNT_W-1:0]              occ;
    logic [IDX_W-1:0]              free_slot;
    logic [IDX_W-1:0]              sel_idx;
    logic                          sel_any;
    logic                          admit;
    logic                          link_resp;
    logic                          release_en;
    pick_e                         pick_q;

    sched_admit #(.DEPTH(DEPTH)) u_admit (
        .hi_mode  (hi_prio_mode),
        .req_prio (in_prio),
        .occ      (occ),
        .used     (used),
        .ready    (in_ready),
        .slot     (free_slot)
    );

    assign admit      = in_valid && in_ready;
    assign link_resp  = resp_valid && sel_any;
    assign release_en = link_resp && !resp_retry;

    sched_store #(.DEPTH(DEPTH), .ID_W(ID_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (admit),
        .wr_slot (free_slot),
        .wr_id   (in_id),
        .wr_prio (in_prio),
        .rm_en   (release_en),
        .rm_slot (sel_idx),
        .used    (used),
        .ids     (ids),
        .prios   (prios),
        .ranks   (ranks),
        .occ     (occ)
    );

    sched_select #(.DEPTH(DEPTH)) u_select (
        .used  (used),
        .prios (prios),
        .ranks (ranks),
        .pick  (pick_q),
        .any   (sel_any),
        .sel   (sel_idx)
    );

    // A retry to an oldest-first presentation arms one priority pick; any
    // response to that pick returns to oldest-first.
    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= PICK_OLDEST;
        end else if (link_resp) begin
            pick_q <= (pick_q == PICK_OLDEST && resp_retry) ? PICK_TOPPRIO : PICK_OLDEST;
        end
    end

    assign tx_valid = sel_any;
    assign tx_id    = ids[sel_idx];
    assign tx_prio  = prios[sel_idx];

endmodule

// File: rtl/prio_wm_sched_chk.sv
module prio_wm_sched_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             hi_prio_mode,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_prio,
    input logic             tx_valid,
    input logic             resp_valid,
    input logic             resp_retry,
    input logic [CNT_W-1:0] occ,
    input logic             pick_top
);

    logic take;
    assign take = in_valid && in_ready;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);                                                    // R8
    AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        tx_valid && resp_valid && resp_retry && !take |=> occ == $past(occ));   // R5
    AST_RETRY_ARMS: assert property (@(posedge clk) disable iff (rst)
        tx_valid && resp_valid && resp_retry && !pick_top |=> pick_top);       // R3
    AST_PICK_ONCE: assert property (@(posedge clk) disable iff (rst)
        tx_valid && resp_valid && pick_top |=> !pick_top);                     // R4
    AST_HI_P0_CAP: assert property (@(posedge clk) disable iff (rst)
        hi_prio_mode && take && in_prio == 2'd0 |-> occ < CNT_W'(2));          // R6
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        occ == '0 |-> !tx_valid);                                              // R11
    AST_NET_ZERO: assert property (@(posedge clk) disable iff (rst)
        take && tx_valid && resp_valid && !resp_retry |=> occ == $past(occ));  // R10

endmodule

bind prio_wm_sched prio_wm_sched_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hi_prio_mode (hi_prio_mode),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_prio      (in_prio),
    .tx_valid     (tx_valid),
    .resp_valid   (resp_valid),
    .resp_retry   (resp_retry),
    .occ          (occ),
    .pick_top     (pick_q == sched_pkg::PICK_TOPPRIO)
);

// File: tb/prio_wm_sched_bench.sv
`timescale 1ns/100ps
module prio_wm_sched_bench;

    localparam int ID_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            hi_prio_mode = 1'b0;
    logic            in_valid = 1'b0;
    logic [ID_W-1:0] in_id = '0;
    logic [1:0]      in_prio = '0;
    logic            in_ready;
    logic            tx_valid;
    logic [ID_W-1:0] tx_id;
    logic [1:0]      tx_prio;
    logic            resp_valid = 1'b0;
    logic            resp_retry = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prio_wm_sched #(.DEPTH(8), .ID_W(ID_W)) u_prio_wm_sched (
        .clk(clk), .rst(rst), .hi_prio_mode(hi_prio_mode),
        .in_valid(in_valid), .in_id(in_id), .in_prio(in_prio), .in_ready(in_ready),
        .tx_valid(tx_valid), .tx_id(tx_id), .tx_prio(tx_prio),
        .resp_valid(resp_valid), .resp_retry(resp_retry)
    );

    // Admission vectors: {mode, fill count, probe priority, expected ready}
    localparam int NVEC = 11;
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b1, 4'd1, 2'd0, 1'b1}, {1'b1, 4'd2, 2'd0, 1'b0},
        {1'b1, 4'd3, 2'd1, 1'b1}, {1'b1, 4'd4, 2'd1, 1'b0},
        {1'b1, 4'd5, 2'd2, 1'b1}, {1'b1, 4'd6, 2'd2, 1'b0},
        {1'b1, 4'd7, 2'd3, 1'b1}, {1'b1, 4'd8, 2'd3, 1'b0},
        {1'b0, 4'd7, 2'd0, 1'b1}, {1'b0, 4'd8, 2'd0, 1'b0},
        {1'b0, 4'd0, 2'd2, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        hi_prio_mode = mode;
        in_valid = 1'b0; resp_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic push(input int id, input int p);
        in_valid = 1'b1; in_id = ID_W'(id); in_prio = 2'(p);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic respond(input logic retry);
        resp_valid = 1'b1; resp_retry = retry;
        @(posedge clk);
        #1 resp_valid = 1'b0;
    endtask

    task automatic expect_tx(input int id, input string tag);
        check(tx_valid === 1'b1 && tx_id === ID_W'(id), tag, int'(tx_id), id);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: reset state
        do_reset(1'b1);
        in_prio = 2'd0;
        #1;
        check(tx_valid === 1'b0, "R1 tx_valid after reset", int'(tx_valid), 0);
        check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // R6 / R7: watermark table
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VEC[v][7]);
            for (int k = 0; k < int'(VEC[v][6:3]); k++) push(100 + k, 3);
            in_prio = VEC[v][2:1];
            #1;
            check(in_ready === VEC[v][0], VEC[v][7] ? "R6 watermark" : "R7 fair share",
                  int'(in_ready), int'(VEC[v][0]));
        end

        // R2: oldest-first regardless of priority; R11 empty after drain
        do_reset(1'b0);
        push(1, 0); push(2, 3); push(3, 1);
        #1 expect_tx(1, "R2 oldest first a");
        respond(1'b0); #1 expect_tx(2, "R2 oldest first b");
        respond(1'b0); #1 expect_tx(3, "R2 oldest first c");
        respond(1'b0); #1;
        check(tx_valid === 1'b0, "R11 empty after drain", int'(tx_valid), 0);
        respond(1'b0); #1;
        push(4, 2); #1 expect_tx(4, "R11 idle response ignored");

        // R3 / R4 / R5: retry picks top priority once, retried packet kept
        do_reset(1'b0);
        push(10, 0); push(11, 2); push(12, 3); push(13, 3);
        #1 expect_tx(10, "R2 mixed oldest");
        respond(1'b1); #1 expect_tx(12, "R3 top-priority pick");
        respond(1'b1); #1 expect_tx(10, "R4 fallback after retried pick");
        respond(1'b1); #1 expect_tx(12, "R3 second retry pick");
        respond(1'b0); #1 expect_tx(10, "R5 retried packet still oldest");
        respond(1'b0); #1 expect_tx(11, "R4 oldest-first resumes");
        respond(1'b0); #1 expect_tx(13, "R5 remaining packet");

        // R9: uniform priority
        do_reset(1'b0);
        push(20, 1); push(21, 1); push(22, 1);
        respond(1'b1); #1 expect_tx(20, "R9 uniform priority retry");

        // R8: refused descriptor held until space frees
        do_reset(1'b1);
        push(30, 3); push(31, 3);
        in_valid = 1'b1; in_id = 8'd32; in_prio = 2'd0;
        #1 check(in_ready === 1'b0, "R8 refused over watermark", int'(in_ready), 0);
        @(posedge clk); #1 expect_tx(30, "R8 order unchanged while held");
        resp_valid = 1'b1; resp_retry = 1'b0;
        @(posedge clk); #1 resp_valid = 1'b0;
        check(in_ready === 1'b1, "R8 ready after free", int'(in_ready), 1);
        @(posedge clk); #1 in_valid = 1'b0;
        expect_tx(31, "R8 next oldest");
        respond(1'b0); #1 expect_tx(32, "R8 held descriptor admitted");

        // R10: admit and free in the same cycle
        do_reset(1'b1);
        push(40, 3);
        in_valid = 1'b1; in_id = 8'd41; in_prio = 2'd0;
        resp_valid = 1'b1; resp_retry = 1'b0;
        @(posedge clk); #1 in_valid = 1'b0; resp_valid = 1'b0;
        expect_tx(41, "R10 new entry presented");
        in_prio = 2'd0; #1;
        check(in_ready === 1'b1, "R10 occupancy one", int'(in_ready), 1);
        push(42, 0); in_prio = 2'd0; #1;
        check(in_ready === 1'b0, "R10 occupancy two", int'(in_ready), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule